// File: doc/BRIEF.md
# Full-Duplex Frame Sequencer

This block frames one exchange on a half-rate full-duplex radio link. Host writes fill a TX byte buffer. When the link is ready, the block puts the frame on `tx_bit`, one bit per data-clock tick, most significant bit first. The frame is a header followed by the buffered data bytes, and the header depends on the role. As master, it waits for PLL lock and for a programmed number of buffered bytes. It then enables the power amplifier and sends a preamble, a zero start bit, the sync bytes FF 00 00, and then the data. As slave, it enables the amplifier as soon as the PLL locks and lets the receive path settle for a programmed time. Once an external start-bit detector has pulsed and enough bytes are buffered, it answers with the sync bytes 00 7F FF and its data.

During the data block, each received bit is XORed with the bit sent in the same slot. The results are packed into bytes and stored in a 16-byte RX buffer. When the TX buffer is found empty at a byte boundary, the block raises an interrupt, keeps the amplifier on for a programmed tail, and then switches it off. The host can read the RX buffer and request its byte count. A single idle command returns everything to the reset state.

Top module: `fdx_frame_seq`

## Requirements
- R1: As master, at a tick with `pll_lock` high and TX byte count >= N, `pa_en` rises. From the next cycle, `tx_bit` carries 39 ones, one zero, then the bytes FF, 00, 00, one bit per tick, MSB first.
- R2: As slave, a tick with `pll_lock` high raises `pa_en`. For the next SETTLE_DLY ticks, `start_det` pulses are ignored and `tx_bit` stays 0. After that, a `start_det` pulse (remembered) together with TX count >= N starts the bytes 00, 7F, FF, MSB first.
- R3: N is the value on `fill_level` (0 to 16). With N = 0, the frame starts even when the TX buffer is empty. With fewer than N bytes buffered, `pa_en` stays low.
- R4: After the header, the data bytes are taken from the TX buffer in write order and sent MSB first, one bit per tick.
- R5: For each data-block slot, `rx_bit` XOR the sent bit is shifted into an RX byte, first slot into bit 7. Header slots are not stored.
- R6: When the TX buffer is empty at the end of a byte, `irq` goes high and stays high until idle. `tx_bit` goes to 0. `pa_en` stays high for PA_OFF_DLY further ticks and then goes low.
- R7: While `cnt_req` is high, `stat_cnt` shows the number of bytes held in the RX buffer. Otherwise it is 0.
- R8: The RX buffer holds 16 bytes. A byte completed while the buffer is full is dropped, and `rx_ovf` sets and stays set until idle.
- R9: A cycle with `idle_cmd` high empties both buffers, clears `irq` and `rx_ovf`, and returns the block to the reset state (`pa_en` = 0, `tx_bit` = 0).
- R10: In a cycle with `bit_tick` low, neither the frame nor the delays advance: `tx_bit` and `pa_en` hold their values.
- R11: `rx_data` shows the oldest RX byte. A cycle with `rx_rd` high and the buffer non-empty removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_slave | input | 1 | Role select: 0 master, 1 slave |
| idle_cmd | input | 1 | Return to reset state, clear buffers |
| fill_level | input | 5 | Byte threshold N (0..16) |
| pll_lock | input | 1 | PLL lock indication |
| start_det | input | 1 | Single-cycle start-bit detection (slave) |
| bit_tick | input | 1 | Data-clock tick enable |
| rx_bit | input | 1 | Received bit for the current slot |
| tx_wr | input | 1 | Push `tx_data` into the TX buffer |
| tx_data | input | 8 | TX byte |
| rx_rd | input | 1 | Pop the oldest RX byte |
| cnt_req | input | 1 | Request RX byte count on `stat_cnt` |
| tx_bit | output | 1 | Transmitted bit |
| pa_en | output | 1 | Power-amplifier enable |
| irq | output | 1 | TX buffer ran dry |
| rx_ovf | output | 1 | RX byte dropped on full buffer |
| rx_data | output | 8 | Oldest RX byte |
| stat_cnt | output | 5 | RX byte count while requested |

## Verification
The assertions assume three things about the inputs. `is_slave` and `fill_level` change only while the block is idle. `pll_lock` stays high for the whole frame. The host never writes into a full TX buffer. The stimulus follows these rules by changing role and threshold only after dropping `pll_lock` and issuing an idle cycle. It keeps lock high until `pa_en` falls, and it never has more than 16 bytes pending. The start pulse is issued both inside and after the slave's settle window. The tick enable is run continuous, thinned to one in three, and held low for a stretch.

// File: rtl/fdx_pkg.sv
// Shared types and header patterns for the full-duplex frame sequencer.
// Assumes 8-bit frame bytes; header contents are fixed by the link format.
package fdx_pkg;

    localparam int BYTE_W         = 8;
    localparam int MASTER_HDR_LEN = 8;
    localparam int SLAVE_HDR_LEN  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_HUNT,
        ST_SEND,
        ST_TAIL,
        ST_DONE
    } fdx_state_e;

    // Header byte at position idx for the given role.
    function automatic logic [BYTE_W-1:0] hdr_byte(input logic slave, input logic [3:0] idx);
        logic [BYTE_W-1:0] b;
        if (slave) begin
            case (idx)
                4'd0:    b = 8'h00;
                4'd1:    b = 8'h7F;
                default: b = 8'hFF;
            endcase
        end else begin
            if (idx < 4'd4)       b = 8'hFF;
            else if (idx == 4'd4) b = 8'hFE;
            else if (idx == 4'd5) b = 8'hFF;
            else                  b = 8'h00;
        end
        return b;
    endfunction

endpackage

// File: rtl/fdx_byte_fifo.sv
// Byte FIFO with combinational head output and an occupancy count.
// Assumes the owner drops writes when count == DEPTH (writes when full are ignored here).
module fdx_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic          wr_ok;
    logic          rd_ok;

    assign wr_ok   = wr_en && (count != CW'(DEPTH));
    assign rd_ok   = rd_en && (count != '0);
    assign rd_data = mem[rp];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

endmodule

// File: rtl/fdx_rx_packer.sv
// Packs (received XOR transmitted) bits into bytes, first bit into the MSB.
// Assumes shift_en only in data-block slots, which are byte aligned.
module fdx_rx_packer #(
    parameter int W   = 8,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         rx_bit,
    input  logic         tx_bit,
    output logic         byte_valid,
    output logic [W-1:0] byte_out
);

    logic [W-2:0]  acc;
    logic [CW-1:0] cnt;
    logic          bit_x;

    assign bit_x      = rx_bit ^ tx_bit;
    assign byte_valid = shift_en && (cnt == CW'(W - 1));
    assign byte_out   = {acc, bit_x};

    // Accumulate one slot result per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
            cnt <= '0;
        end else if (shift_en) begin
            acc <= {acc[W-3:0], bit_x};
            cnt <= byte_valid ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fdx_frame_seq.sv
// Full-duplex frame sequencer: role-dependent start, header and data
// serialisation, XOR capture into the RX buffer, interrupt and amplifier tail.
// Assumes is_slave and fill_level stable outside idle, pll_lock held during a frame.
module fdx_frame_seq
    import fdx_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int SETTLE_DLY = 8,
    parameter int PA_OFF_DLY = 8,
    localparam int CW        = $clog2(DEPTH + 1),
    localparam int DLY_MAX   = (SETTLE_DLY > PA_OFF_DLY) ? SETTLE_DLY : PA_OFF_DLY,
    localparam int DLY_W     = $clog2(DLY_MAX + 1),
    localparam int BC_W      = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_slave,
    input  logic              idle_cmd,
    input  logic [CW-1:0]     fill_level,
    input  logic              pll_lock,
    input  logic              start_det,
    input  logic              bit_tick,
    input  logic              rx_bit,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              cnt_req,
    output logic              tx_bit,
    output logic              pa_en,
    output logic              irq,
    output logic              rx_ovf,
    output logic [BYTE_W-1:0] rx_data,
    output logic [CW-1:0]     stat_cnt
);

    fdx_state_e        state;
    logic [BYTE_W-1:0] sr;
    logic [BC_W-1:0]   bit_cnt;
    logic [3:0]        hdr_idx;
    logic [3:0]        hdr_len;
    logic              data_ph;
    logic [DLY_W-1:0]  dly;
    logic              start_seen;

    logic [BYTE_W-1:0] tx_head;
    logic [CW-1:0]     tx_count;
    logic [CW-1:0]     rx_count;
    logic              tx_empty;
    logic              fill_ok;
    logic              byte_end;
    logic              pop_tx;
    logic              pk_shift;
    logic              pk_valid;
    logic [BYTE_W-1:0] pk_byte;
    logic              rx_drop;

    assign hdr_len  = is_slave ? 4'(SLAVE_HDR_LEN) : 4'(MASTER_HDR_LEN);
    assign tx_empty = (tx_count == '0);
    assign fill_ok  = (tx_count >= fill_level);
    assign byte_end = bit_tick && (state == ST_SEND) && (bit_cnt == BC_W'(BYTE_W - 1));
    assign pop_tx   = byte_end && (hdr_idx == hdr_len) && !tx_empty;
    assign pk_shift = bit_tick && (state == ST_SEND) && data_ph;
    assign rx_drop  = pk_valid && (rx_count == CW'(DEPTH));

    assign tx_bit   = (state == ST_SEND) && sr[BYTE_W-1];
    assign pa_en    = (state == ST_SETTLE) || (state == ST_HUNT) ||
                      (state == ST_SEND)   || (state == ST_TAIL);
    assign stat_cnt = cnt_req ? rx_count : '0;

    fdx_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_tx_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (idle_cmd),
        .wr_en   (tx_wr),
        .wr_data (tx_data),
        .rd_en   (pop_tx),
        .rd_data (tx_head),
        .count   (tx_count)
    );

    fdx_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rx_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (idle_cmd),
        .wr_en   (pk_valid),
        .wr_data (pk_byte),
        .rd_en   (rx_rd),
        .rd_data (rx_data),
        .count   (rx_count)
    );

    fdx_rx_packer #(.W(BYTE_W)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (idle_cmd),
        .shift_en   (pk_shift),
        .rx_bit     (rx_bit),
        .tx_bit     (sr[BYTE_W-1]),
        .byte_valid (pk_valid),
        .byte_out   (pk_byte)
    );

    // Frame sequencing: start conditions, header/data shifting, delays, interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || idle_cmd) begin
            state      <= ST_IDLE;
            sr         <= '0;
            bit_cnt    <= '0;
            hdr_idx    <= '0;
            data_ph    <= 1'b0;
            dly        <= '0;
            start_seen <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (state == ST_HUNT && start_det) start_seen <= 1'b1;
            if (bit_tick) begin
                case (state)
                    ST_IDLE: begin
                        if (pll_lock) begin
                            if (is_slave) begin
                                state <= ST_SETTLE;
                                dly   <= '0;
                            end else if (fill_ok) begin
                                state   <= ST_SEND;
                                sr      <= hdr_byte(1'b0, 4'd0);
                                hdr_idx <= 4'd1;
                                bit_cnt <= '0;
                                data_ph <= 1'b0;
                            end
                        end
                    end
                    ST_SETTLE: begin
                        if (dly == DLY_W'(SETTLE_DLY - 1)) begin
                            state      <= ST_HUNT;
                            start_seen <= 1'b0;
                        end else begin
                            dly <= dly + 1'b1;
                        end
                    end
                    ST_HUNT: begin
                        if ((start_seen || start_det) && fill_ok) begin
                            state   <= ST_SEND;
                            sr      <= hdr_byte(1'b1, 4'd0);
                            hdr_idx <= 4'd1;
                            bit_cnt <= '0;
                            data_ph <= 1'b0;
                        end
                    end
                    ST_SEND: begin
                        if (byte_end) begin
                            bit_cnt <= '0;
                            if (hdr_idx < hdr_len) begin
                                sr      <= hdr_byte(is_slave, hdr_idx);
                                hdr_idx <= hdr_idx + 1'b1;
                            end else if (!tx_empty) begin
                                sr      <= tx_head;
                                data_ph <= 1'b1;
                            end else begin
                                state <= ST_TAIL;
                                dly   <= '0;
                                irq   <= 1'b1;
                            end
                        end else begin
                            sr      <= {sr[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        if (dly == DLY_W'(PA_OFF_DLY - 1)) state <= ST_DONE;
                        else                               dly   <= dly + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Sticky overflow flag for bytes dropped on a full RX buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || idle_cmd) rx_ovf <= 1'b0;
        else if (rx_drop)       rx_ovf <= 1'b1;
    end

endmodule

// File: rtl/fdx_frame_seq_chk.sv
// Property checker for fdx_frame_seq, bound to every instance.
// Assumes pll_lock is held high for the duration of a frame.
module fdx_frame_seq_chk
    import fdx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       idle_cmd,
    input logic       pll_lock,
    input logic       bit_tick,
    input logic       tx_bit,
    input logic       pa_en,
    input logic       irq,
    input logic       rx_ovf,
    input logic [CW-1:0] rx_count,
    input fdx_state_e state
);

    assert_lock_before_pa_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pa_en) |-> $past(pll_lock));

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_en |-> !tx_bit);

    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !idle_cmd) |=> irq);

    assert_no_irq_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> !irq);

    assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !idle_cmd) |=> rx_ovf);

    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd |=> (!pa_en && !irq && !rx_ovf && rx_count == '0));

    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !idle_cmd) |=> ($stable(tx_bit) && $stable(pa_en)));

endmodule

bind fdx_frame_seq fdx_frame_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_cmd (idle_cmd),
    .pll_lock (pll_lock),
    .bit_tick (bit_tick),
    .tx_bit   (tx_bit),
    .pa_en    (pa_en),
    .irq      (irq),
    .rx_ovf   (rx_ovf),
    .rx_count (rx_count),
    .state    (state)
);

// File: tb/fdx_frame_seq_bench.sv
module fdx_frame_seq_bench;
    localparam int DEPTH  = 16;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int SETTLE = 6;
    localparam int OFFD   = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, is_slave = 1'b0, idle_cmd = 1'b0, pll_lock = 1'b0;
    logic start_det = 1'b0, bit_tick = 1'b1, rx_bit = 1'b0, tx_wr = 1'b0;
    logic rx_rd = 1'b0, cnt_req = 1'b0;
    logic [CW-1:0] fill_level = '0;
    logic [7:0] tx_data = '0;
    logic tx_bit, pa_en, irq, rx_ovf;
    logic [7:0] rx_data;
    logic [CW-1:0] stat_cnt;

    fdx_frame_seq #(.DEPTH(DEPTH), .SETTLE_DLY(SETTLE), .PA_OFF_DLY(OFFD)) u_fdx_frame_seq (
        .clk(clk), .rst_n(rst_n), .is_slave(is_slave), .idle_cmd(idle_cmd),
        .fill_level(fill_level), .pll_lock(pll_lock), .start_det(start_det),
        .bit_tick(bit_tick), .rx_bit(rx_bit), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .cnt_req(cnt_req), .tx_bit(tx_bit), .pa_en(pa_en),
        .irq(irq), .rx_ovf(rx_ovf), .rx_data(rx_data), .stat_cnt(stat_cnt));

    int total = 0, bad = 0, cyc = 0;
    int rx_mode = 0;    // 0: const 0, 1: const 1, 2: pattern
    int tick_mode = 0;  // 0: every cycle, 1: one in three, 2: none
    bit cmp_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Free-running stimulus for rx_bit and bit_tick.
    always @(negedge clk) begin
        cyc++;
        rx_bit   <= (rx_mode == 2) ? (cyc[0] ^ cyc[2]) : rx_mode[0];
        bit_tick <= (tick_mode == 0) || (tick_mode == 1 && (cyc % 3) == 0);
    end

    // ---------------- reference model ----------------
    localparam int M_IDLE = 0, M_SETTLE = 1, M_HUNT = 2, M_SEND = 3, M_TAIL = 4, M_DONE = 5;
    int m_st = M_IDLE, m_dly = 0, acc = 0, nacc = 0;
    bit m_seen = 0, m_irq = 0, m_ovf = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int bitq[$];  // bit | (is_data << 1)

    function automatic void push_byte(input logic [7:0] b, input int is_data);
        for (int i = 7; i >= 0; i--) bitq.push_back(int'(b[i]) + 2 * is_data);
    endfunction

    function automatic void start_frame(input bit slave);
        bitq.delete();
        if (slave) begin
            push_byte(8'h00, 0); push_byte(8'h7F, 0); push_byte(8'hFF, 0);
        end else begin
            for (int i = 0; i < 4; i++) push_byte(8'hFF, 0);
            push_byte(8'hFE, 0); push_byte(8'hFF, 0); push_byte(8'h00, 0); push_byte(8'h00, 0);
        end
        m_st = M_SEND;
    endfunction

    always @(posedge clk) begin
        bit tx_full_pre, rx_full_pre, rx_empty_pre;
        int b;
        tx_full_pre  = (txq.size() >= DEPTH);
        rx_full_pre  = (rxq.size() >= DEPTH);
        rx_empty_pre = (rxq.size() == 0);
        if (!rst_n || idle_cmd) begin
            m_st = M_IDLE; m_dly = 0; acc = 0; nacc = 0;
            m_seen = 0; m_irq = 0; m_ovf = 0;
            txq.delete(); rxq.delete(); bitq.delete();
        end else begin
            if (m_st == M_HUNT && start_det) m_seen = 1;
            if (bit_tick) begin
                case (m_st)
                    M_IDLE: if (pll_lock) begin
                        if (is_slave) begin m_st = M_SETTLE; m_dly = 0; end
                        else if (txq.size() >= int'(fill_level)) start_frame(0);
                    end
                    M_SETTLE: if (m_dly == SETTLE - 1) begin m_st = M_HUNT; m_seen = 0; end
                              else m_dly++;
                    M_HUNT: if (m_seen && txq.size() >= int'(fill_level)) start_frame(1);
                    M_SEND: begin
                        b = bitq.pop_front();
                        if (b >= 2) begin
                            acc = ((acc << 1) | ((b & 1) ^ int'(rx_bit))) & 255;
                            nacc++;
                            if (nacc == 8) begin
                                if (rx_full_pre) m_ovf = 1;
                                else rxq.push_back(8'(acc));
                                nacc = 0;
                            end
                        end
                        if (bitq.size() == 0) begin
                            if (txq.size() > 0) push_byte(txq.pop_front(), 1);
                            else begin m_st = M_TAIL; m_dly = 0; m_irq = 1; end
                        end
                    end
                    M_TAIL: if (m_dly == OFFD - 1) m_st = M_DONE; else m_dly++;
                    default: ;
                endcase
            end
            if (rx_rd && !rx_empty_pre) void'(rxq.pop_front());
            if (tx_wr && !tx_full_pre) txq.push_back(tx_data);
        end
    end

    // Compare DUT with model every cycle, away from the active edge.
    always @(negedge clk) begin
        #8;
        if (cmp_on) begin
            int e_tx, e_pa, e_cnt;
            string req;
            e_tx = (m_st == M_SEND) ? (bitq[0] & 1) : 0;
            e_pa = (m_st == M_SETTLE || m_st == M_HUNT || m_st == M_SEND || m_st == M_TAIL) ? 1 : 0;
            e_cnt = cnt_req ? rxq.size() : 0;
            req = (m_st == M_SEND && bitq[0] >= 2) ? "R4" : (is_slave ? "R2" : "R1");
            check(int'(tx_bit) == e_tx, req, "tx_bit", int'(tx_bit), e_tx);
            check(int'(pa_en) == e_pa, "R6", "pa_en", int'(pa_en), e_pa);
            check(irq == m_irq, "R6", "irq", int'(irq), int'(m_irq));
            check(rx_ovf == m_ovf, "R8", "rx_ovf", int'(rx_ovf), int'(m_ovf));
            check(int'(stat_cnt) == e_cnt, "R7", "stat_cnt", int'(stat_cnt), e_cnt);
            if (rxq.size() > 0)
                check(rx_data == rxq[0], "R11", "rx_data", int'(rx_data), int'(rxq[0]));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog R9 act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed sequences ----------------
    task automatic step(); @(negedge clk); #5; endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_wr = 1; tx_data = b;
        @(negedge clk); tx_wr = 0; #5;
    endtask

    task automatic go_idle();
        @(negedge clk); pll_lock = 0; idle_cmd = 1;
        @(negedge clk); idle_cmd = 0; #5;
    endtask

    task automatic wait_pa(input bit lvl, input string req);
        int n = 0;
        while (pa_en !== lvl && n < 2000) begin step(); n++; end
        check(pa_en === lvl, req, "pa_en wait", int'(pa_en), int'(lvl));
    endtask

    task automatic pop_check(input logic [7:0] exp, input string req);
        check(rx_data == exp, req, "rx byte", int'(rx_data), int'(exp));
        @(negedge clk); rx_rd = 1;
        @(negedge clk); rx_rd = 0; #5;
    endtask

    initial begin
        logic [7:0] d1 [4];
        int errs, n, hold_tx, hold_pa;
        d1[0] = 8'hA5; d1[1] = 8'h3C; d1[2] = 8'h01; d1[3] = 8'hF0;
        repeat (3) @(negedge clk);
        rst_n = 1; cnt_req = 1;
        step();
        // R9: reset state
        check(!tx_bit && !pa_en && !irq && !rx_ovf && stat_cnt == 0, "R9", "reset outputs",
              {tx_bit, pa_en, irq, rx_ovf}, 0);
        cmp_on = 1;

        // Master, N = 4, threshold gating then frame with rx held at 1.
        rx_mode = 1; fill_level = 4;
        for (int i = 0; i < 3; i++) push_tx(d1[i]);
        pll_lock = 1;
        repeat (8) step();
        check(!pa_en, "R3", "pa_en below threshold", int'(pa_en), 0);
        push_tx(d1[3]);
        wait_pa(1, "R1");
        errs = 0;
        for (int i = 0; i < 64; i++) begin
            int e;
            e = (i < 39) ? 1 : (i == 39) ? 0 : (i < 48) ? 1 : 0;
            if (int'(tx_bit) != e) errs++;
            step();
        end
        check(errs == 0, "R1", "master header mismatches", errs, 0);
        n = 0;
        while (pa_en && n < 500) begin if (irq) n++; step(); end
        check(n == OFFD, "R6", "irq-to-pa_off ticks", n, OFFD);
        check(irq, "R6", "irq after dry", int'(irq), 1);
        check(stat_cnt == 4, "R7", "rx count", int'(stat_cnt), 4);
        for (int i = 0; i < 4; i++) pop_check(~d1[i], "R5");
        go_idle();
        check(!irq && stat_cnt == 0, "R9", "idle clears", int'(irq) + int'(stat_cnt), 0);

        // Slave, N = 2, early start pulse ignored.
        is_slave = 1; fill_level = 2; rx_mode = 2;
        push_tx(8'h96); push_tx(8'h4B);
        pll_lock = 1;
        repeat (2) step();
        check(pa_en, "R2", "slave pa on lock", int'(pa_en), 1);
        @(negedge clk); start_det = 1; @(negedge clk); start_det = 0; #5;
        errs = 0;
        for (int i = 0; i < 20; i++) begin if (tx_bit) errs++; step(); end
        check(errs == 0 && pa_en, "R2", "start in settle ignored", errs, 0);
        @(negedge clk); start_det = 1; @(negedge clk); start_det = 0; #5;
        errs = 0;
        for (int i = 0; i < 24; i++) begin
            int e;
            e = (i < 9) ? 0 : 1;
            if (int'(tx_bit) != e) errs++;
            step();
        end
        check(errs == 0, "R2", "slave header mismatches", errs, 0);
        wait_pa(0, "R6");
        check(stat_cnt == 2, "R7", "slave rx count", int'(stat_cnt), 2);
        repeat (2) begin @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0; #5; end
        go_idle();

        // Master, N = 0, empty buffer starts anyway.
        is_slave = 0; fill_level = 0; rx_mode = 0;
        pll_lock = 1;
        repeat (3) step();
        check(pa_en, "R3", "N=0 start", int'(pa_en), 1);
        wait_pa(0, "R6");
        check(stat_cnt == 0 && irq, "R7", "header-only count", int'(stat_cnt), 0);
        go_idle();

        // Overflow: 18 data bytes into a 16-byte RX buffer.
        fill_level = 16; rx_mode = 0;
        for (int i = 0; i < 16; i++) push_tx(8'(i * 7 + 3));
        pll_lock = 1;
        wait_pa(1, "R8");
        repeat (80) step();
        push_tx(8'hEE); push_tx(8'h11);
        wait_pa(0, "R6");
        check(stat_cnt == 16, "R8", "rx full count", int'(stat_cnt), 16);
        check(rx_ovf, "R8", "overflow flag", int'(rx_ovf), 1);
        pop_check(8'd3, "R5");
        pop_check(8'd10, "R11");
        go_idle();

        // Thinned ticks, a held stretch, then idle mid-frame.
        tick_mode = 1; fill_level = 1; rx_mode = 2;
        push_tx(8'h5A);
        pll_lock = 1;
        wait_pa(1, "R10");
        repeat (20) step();
        tick_mode = 2;
        repeat (3) step();
        hold_tx = int'(tx_bit); hold_pa = int'(pa_en);
        errs = 0;
        for (int i = 0; i < 12; i++) begin
            if (int'(tx_bit) != hold_tx || int'(pa_en) != hold_pa) errs++;
            step();
        end
        check(errs == 0, "R10", "hold without tick", errs, 0);
        tick_mode = 1;
        repeat (30) step();
        @(negedge clk); idle_cmd = 1; @(negedge clk); idle_cmd = 0; #5;
        check(!pa_en && !tx_bit && stat_cnt == 0, "R9", "idle mid-frame", int'(pa_en), 0);
        pll_lock = 0; tick_mode = 0;
        repeat (5) step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule